// File: doc/BRIEF.md
# Byte-Granular Register Hazard Tracker

This block decides whether an operation may claim a portion of a 64-bit architectural register while other operations still hold other portions of it. Every register is split into eight byte lanes. An operation asks for an 8-, 16-, 32- or 64-bit element at a byte offset. The tracker turns that request into a lane mask and grants it only when none of those lanes is currently held. A reserve on the low byte therefore blocks the enclosing halfword, word and full register. Bytes and halfwords elsewhere in the same register stay available.

Each claim belongs to a function-unit tag. A tag holds at most one claim, which records the register and the lanes it took. When a unit completes, it releases by tag. The tracker then frees exactly the lanes that tag recorded, so units may complete in any order. There is one reserve port and one release port per cycle. A reserve arriving in the same cycle as a release is judged against the state after that release. The per-register lane occupancy is derived from the tag table and driven out so that issue logic can see it.

Top module: `byte_hazard_tracker`

## Requirements
- R1: After reset no lane of any register is busy, and no grant is given while no reserve is requested.
- R2: The size code (0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit) and the byte offset `off` map to lanes as follows. 8-bit takes lane `off`. 16-bit takes lanes `off` and `off+1`. 32-bit takes lanes `off` to `off+3`. 64-bit takes all eight lanes. Bit k of a register's busy byte is lane k, and register r occupies `busy_lanes[8r+7:8r]`.
- R3: A reserve is granted only if its lanes do not intersect the busy lanes of its register. A refused reserve raises `rsv_stall` and changes no state.
- R4: While a full 64-bit claim is held on a register, every 8-, 16- and 32-bit reserve on that register is refused.
- R5: While only a single byte is held, every reserve whose lanes avoid that byte is granted, including other bytes and the other halfwords. Reserves of the enclosing halfword, word and full register are refused.
- R6: A 16-bit offset that is odd, a 32-bit offset that is not 0 or 4, and any nonzero 64-bit offset raise `rsv_misalign`. Such a reserve gets no grant and reserves nothing.
- R7: A release clears exactly the lanes recorded for its tag, whatever the order of releases. A release naming a tag that holds nothing changes no lane.
- R8: When a release and a reserve occur in the same cycle, the reserve is judged on the state after the release. This holds for the lanes and for reuse of the released tag.
- R9: A reserve whose tag already holds a claim, and is not being released that cycle, is refused.
- R10: Claims on different registers never interact.
- R11: A granted claim appears in `busy_lanes` from the cycle after the grant. A release disappears from it from the cycle after the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rsv_valid | input | 1 | Reserve request |
| rsv_reg | input | RIDX_W | Register index of the reserve |
| rsv_size | input | 2 | Element size code (R2) |
| rsv_offset | input | 3 | Byte offset of the element |
| rsv_tag | input | TAG_W | Function-unit tag claiming the element |
| rel_valid | input | 1 | Release request |
| rel_tag | input | TAG_W | Tag whose claim is released |
| rsv_grant | output | 1 | Reserve accepted this cycle |
| rsv_stall | output | 1 | Reserve requested but refused |
| rsv_misalign | output | 1 | Reserve offset not aligned to its size |
| busy_lanes | output | 8*NUM_REGS | Busy byte lanes of every register |

## Verification
The core sweep places one claim of each of the fifteen aligned shapes on a register. It then requests each of the fifteen shapes on the same register and also on another register. This separates lane-overlap refusal from register independence, and shows the cascade from bytes up to the full register and back down. A sweep over all size and offset codes separates alignment errors from overlap refusals. Directed sequences cover a release paired with a reserve in the same cycle, reuse of a held tag, releases of idle tags and out-of-order completion. A long stretch of random traffic is checked against a lane model, to catch interactions between several live tags.

// File: rtl/bht_pkg.sv
package bht_pkg;
   localparam int LANES = 8;

   typedef enum logic [1:0] {
      SZ_B8  = 2'd0,
      SZ_B16 = 2'd1,
      SZ_B32 = 2'd2,
      SZ_B64 = 2'd3
   } elem_size_e;
endpackage

// File: rtl/bht_lane_decode.sv
module bht_lane_decode
   import bht_pkg::*;
(
   input  logic [1:0] size,
   input  logic [2:0] offset,
   output logic [7:0] lanes,
   output logic       misaligned
);
   elem_size_e sz;
   logic [7:0] raw;

   always_comb begin
      sz = elem_size_e'(size);
      unique case (sz)
         SZ_B8: begin
            raw        = 8'h01 << offset;
            misaligned = 1'b0;
         end
         SZ_B16: begin
            raw        = 8'h03 << {offset[2:1], 1'b0};
            misaligned = offset[0];
         end
         SZ_B32: begin
            raw        = 8'h0F << {offset[2], 2'b00};
            misaligned = |offset[1:0];
         end
         default: begin
            raw        = 8'hFF;
            misaligned = |offset;
         end
      endcase
      lanes = misaligned ? 8'h00 : raw;
   end
endmodule

// File: rtl/bht_tag_slot.sv
module bht_tag_slot #(
   parameter int RIDX_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              clear,
   input  logic [RIDX_W-1:0] load_reg,
   input  logic [7:0]        load_lanes,
   output logic              held,
   output logic [RIDX_W-1:0] held_reg,
   output logic [7:0]        held_lanes
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held       <= 1'b0;
         held_reg   <= '0;
         held_lanes <= '0;
      end else if (load) begin
         held       <= 1'b1;
         held_reg   <= load_reg;
         held_lanes <= load_lanes;
      end else if (clear) begin
         held       <= 1'b0;
         held_lanes <= '0;
      end
   end
endmodule

// File: rtl/bht_busy_merge.sv
module bht_busy_merge #(
   parameter int NUM_REGS = 8,
   parameter int NUM_TAGS = 4,
   parameter int RIDX_W   = 3
) (
   input  logic [NUM_TAGS-1:0]        slot_held,
   input  logic [NUM_TAGS*RIDX_W-1:0] slot_reg,
   input  logic [NUM_TAGS*8-1:0]      slot_lanes,
   input  logic [NUM_TAGS-1:0]        exclude,
   output logic [NUM_REGS*8-1:0]      busy
);
   for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      logic [7:0] acc;
      always_comb begin
         acc = '0;
         for (int t = 0; t < NUM_TAGS; t++) begin
            if (slot_held[t] && !exclude[t] &&
                slot_reg[t*RIDX_W +: RIDX_W] == RIDX_W'(r))
               acc = acc | slot_lanes[t*8 +: 8];
         end
      end
      assign busy[r*8 +: 8] = acc;
   end
endmodule

// File: rtl/byte_hazard_tracker.sv
module byte_hazard_tracker
   import bht_pkg::*;
#(
   parameter int NUM_REGS = 8,
   parameter int NUM_TAGS = 4,
   parameter int RIDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
   parameter int TAG_W    = (NUM_TAGS > 1) ? $clog2(NUM_TAGS) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  rsv_valid,
   input  logic [RIDX_W-1:0]     rsv_reg,
   input  logic [1:0]            rsv_size,
   input  logic [2:0]            rsv_offset,
   input  logic [TAG_W-1:0]      rsv_tag,
   input  logic                  rel_valid,
   input  logic [TAG_W-1:0]      rel_tag,
   output logic                  rsv_grant,
   output logic                  rsv_stall,
   output logic                  rsv_misalign,
   output logic [NUM_REGS*8-1:0] busy_lanes
);
   localparam logic [RIDX_W:0] REG_LIMIT = (RIDX_W+1)'(NUM_REGS);

   if (NUM_REGS < 1) begin : g_bad_regs
      $error("byte_hazard_tracker: NUM_REGS must be at least 1");
   end
   if (NUM_TAGS < 1) begin : g_bad_tags
      $error("byte_hazard_tracker: NUM_TAGS must be at least 1");
   end
   if ((1 << RIDX_W) < NUM_REGS) begin : g_bad_ridx
      $error("byte_hazard_tracker: RIDX_W too narrow for NUM_REGS");
   end
   if ((1 << TAG_W) < NUM_TAGS) begin : g_bad_tagw
      $error("byte_hazard_tracker: TAG_W too narrow for NUM_TAGS");
   end

   logic [7:0]                 req_lanes;
   logic                       req_misaligned;
   logic [NUM_TAGS-1:0]        slot_held;
   logic [NUM_TAGS*RIDX_W-1:0] slot_reg;
   logic [NUM_TAGS*8-1:0]      slot_lanes;
   logic [NUM_TAGS-1:0]        rel_hit;
   logic [NUM_TAGS-1:0]        load_hit;
   logic [NUM_REGS*8-1:0]      post_release;
   logic [7:0]                 target_view;
   logic                       reg_ok;
   logic                       tag_free;

   bht_lane_decode u_decode (
      .size       (rsv_size),
      .offset     (rsv_offset),
      .lanes      (req_lanes),
      .misaligned (req_misaligned)
   );

   for (genvar t = 0; t < NUM_TAGS; t++) begin : g_slot
      assign rel_hit[t]  = rel_valid && (rel_tag == TAG_W'(t));
      assign load_hit[t] = rsv_grant && (rsv_tag == TAG_W'(t));

      bht_tag_slot #(.RIDX_W(RIDX_W)) u_slot (
         .clk        (clk),
         .rst_n      (rst_n),
         .load       (load_hit[t]),
         .clear      (rel_hit[t]),
         .load_reg   (rsv_reg),
         .load_lanes (req_lanes),
         .held       (slot_held[t]),
         .held_reg   (slot_reg[t*RIDX_W +: RIDX_W]),
         .held_lanes (slot_lanes[t*8 +: 8])
      );
   end

   bht_busy_merge #(
      .NUM_REGS (NUM_REGS),
      .NUM_TAGS (NUM_TAGS),
      .RIDX_W   (RIDX_W)
   ) u_visible (
      .slot_held  (slot_held),
      .slot_reg   (slot_reg),
      .slot_lanes (slot_lanes),
      .exclude    ({NUM_TAGS{1'b0}}),
      .busy       (busy_lanes)
   );

   bht_busy_merge #(
      .NUM_REGS (NUM_REGS),
      .NUM_TAGS (NUM_TAGS),
      .RIDX_W   (RIDX_W)
   ) u_post_release (
      .slot_held  (slot_held),
      .slot_reg   (slot_reg),
      .slot_lanes (slot_lanes),
      .exclude    (rel_hit),
      .busy       (post_release)
   );

   always_comb begin
      target_view = '0;
      for (int r = 0; r < NUM_REGS; r++) begin
         if (rsv_reg == RIDX_W'(r))
            target_view = post_release[r*8 +: 8];
      end
      tag_free = 1'b0;
      for (int t = 0; t < NUM_TAGS; t++) begin
         if (rsv_tag == TAG_W'(t))
            tag_free = !slot_held[t] || rel_hit[t];
      end
   end

   assign reg_ok       = {1'b0, rsv_reg} < REG_LIMIT;
   assign rsv_misalign = rsv_valid && req_misaligned;
   assign rsv_grant    = rsv_valid && !req_misaligned && reg_ok && tag_free &&
                         ((target_view & req_lanes) == 8'h00);
   assign rsv_stall    = rsv_valid && !rsv_grant;
endmodule

// File: rtl/bht_checker.sv
module bht_checker #(
   parameter int NUM_REGS = 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  rsv_valid,
   input logic                  rel_valid,
   input logic                  rsv_grant,
   input logic                  rsv_stall,
   input logic                  rsv_misalign,
   input logic [NUM_REGS*8-1:0] busy_lanes
);
   // R1
   grant_needs_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsv_grant |-> rsv_valid);

   // R3
   grant_stall_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsv_grant && rsv_stall));

   // R6
   misalign_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsv_misalign |-> !rsv_grant);

   // R3
   refused_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rsv_grant && !rel_valid) |=> $stable(busy_lanes));

   // R7
   release_adds_nothing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_valid && !rsv_grant) |=> ((busy_lanes & ~$past(busy_lanes)) == '0));

   // R11
   grant_grows_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsv_grant && !rel_valid) |=> ($countones(busy_lanes) > $countones($past(busy_lanes))));
endmodule

bind byte_hazard_tracker bht_checker #(.NUM_REGS(NUM_REGS)) u_bht_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .rsv_valid    (rsv_valid),
   .rel_valid    (rel_valid),
   .rsv_grant    (rsv_grant),
   .rsv_stall    (rsv_stall),
   .rsv_misalign (rsv_misalign),
   .busy_lanes   (busy_lanes)
);

// File: tb/byte_hazard_tracker_bench.sv
`timescale 1ns/100ps
module byte_hazard_tracker_bench;
   localparam int NREG = 8;
   localparam int NTAG = 4;
   localparam int RW   = 3;
   localparam int TW   = 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            rsv_valid = 1'b0;
   logic [RW-1:0]   rsv_reg = '0;
   logic [1:0]      rsv_size = '0;
   logic [2:0]      rsv_offset = '0;
   logic [TW-1:0]   rsv_tag = '0;
   logic            rel_valid = 1'b0;
   logic [TW-1:0]   rel_tag = '0;
   logic            rsv_grant, rsv_stall, rsv_misalign;
   logic [NREG*8-1:0] busy_lanes;

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  m_held [NTAG];
   int  m_reg  [NTAG];
   int  m_mask [NTAG];

   always #2 clk = ~clk;

   byte_hazard_tracker #(.NUM_REGS(NREG), .NUM_TAGS(NTAG)) u_byte_hazard_tracker (
      .clk(clk), .rst_n(rst_n),
      .rsv_valid(rsv_valid), .rsv_reg(rsv_reg), .rsv_size(rsv_size),
      .rsv_offset(rsv_offset), .rsv_tag(rsv_tag),
      .rel_valid(rel_valid), .rel_tag(rel_tag),
      .rsv_grant(rsv_grant), .rsv_stall(rsv_stall), .rsv_misalign(rsv_misalign),
      .busy_lanes(busy_lanes)
   );

   task automatic check(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic int shape_mask(input int sz, input int off);
      int width = 1 << sz;
      return ((1 << width) - 1) << off;
   endfunction

   function automatic bit shape_bad(input int sz, input int off);
      return (off % (1 << sz)) != 0;
   endfunction

   function automatic int model_busy(input int r);
      int acc = 0;
      for (int t = 0; t < NTAG; t++)
         if (m_held[t] && m_reg[t] == r) acc |= m_mask[t];
      return acc;
   endfunction

   task automatic check_all_busy(input string req);
      for (int r = 0; r < NREG; r++)
         check(req, int'(busy_lanes[r*8 +: 8]), model_busy(r));
   endtask

   // One cycle: drive at the falling edge, check outputs, commit at the rising edge.
   task automatic step(input string req, input bit rv, input int r, input int sz,
                       input int off, input int tg, input bit lv, input int lt);
      bit exp_mis, exp_grant, tfree;
      int view;
      @(negedge clk);
      check_all_busy("R11");
      rsv_valid = rv; rsv_reg = RW'(r); rsv_size = 2'(sz); rsv_offset = 3'(off);
      rsv_tag = TW'(tg); rel_valid = lv; rel_tag = TW'(lt);
      #1;
      view = 0;
      for (int t = 0; t < NTAG; t++)
         if (m_held[t] && m_reg[t] == r && !(lv && lt == t)) view |= m_mask[t];
      tfree     = !m_held[tg] || (lv && lt == tg);
      exp_mis   = rv && shape_bad(sz, off);
      exp_grant = rv && !exp_mis && tfree && ((view & shape_mask(sz, off)) == 0);
      check(req, int'(rsv_grant), int'(exp_grant));
      check(req, int'(rsv_stall), int'(rv && !exp_grant));
      check("R6", int'(rsv_misalign), int'(exp_mis));
      @(posedge clk);
      if (lv) begin m_held[lt] = 1'b0; m_mask[lt] = 0; end
      if (exp_grant) begin m_held[tg] = 1'b1; m_reg[tg] = r; m_mask[tg] = shape_mask(sz, off); end
   endtask

   task automatic idle();
      step("R1", 1'b0, 0, 0, 0, 0, 1'b0, 0);
   endtask

   task automatic shape_of(input int idx, output int sz, output int off);
      if (idx < 8)       begin sz = 0; off = idx; end
      else if (idx < 12) begin sz = 1; off = (idx - 8) * 2; end
      else if (idx < 14) begin sz = 2; off = (idx - 12) * 4; end
      else               begin sz = 3; off = 0; end
   endtask

   initial begin : watchdog
      #(4 * 190000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : stimulus
      int sa, oa, sb, ob;
      string lbl;
      for (int t = 0; t < NTAG; t++) begin m_held[t] = 0; m_reg[t] = 0; m_mask[t] = 0; end
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // R1: reset state and idle inputs
      idle();
      idle();

      // Pairwise shape sweep: R2, R3, R4, R5, R10
      for (int a = 0; a < 15; a++) begin
         for (int b = 0; b < 15; b++) begin
            shape_of(a, sa, oa);
            shape_of(b, sb, ob);
            lbl = (sa == 3) ? "R4" : (sa == 0) ? "R5" : "R3";
            step("R2", 1'b1, 2, sa, oa, 0, 1'b0, 0);
            step(lbl,  1'b1, 2, sb, ob, 1, 1'b0, 0);
            step("R10", 1'b1, 5, sb, ob, 2, 1'b0, 0);
            step("R7", 1'b0, 0, 0, 0, 0, 1'b1, 1);
            step("R7", 1'b0, 0, 0, 0, 0, 1'b1, 0);
            step("R7", 1'b0, 0, 0, 0, 0, 1'b1, 2);
         end
      end

      // R6: every size/offset code, aligned or not
      for (int s = 0; s < 4; s++) begin
         for (int o = 0; o < 8; o++) begin
            step("R6", 1'b1, 1, s, o, 3, 1'b0, 0);
            step("R7", 1'b0, 0, 0, 0, 0, 1'b1, 3);
         end
      end

      // R8: release and reserve in one cycle, lanes and tag reuse
      step("R8", 1'b1, 3, 3, 0, 0, 1'b0, 0);
      step("R8", 1'b1, 3, 3, 0, 1, 1'b1, 0);
      step("R8", 1'b1, 4, 2, 4, 1, 1'b1, 1);
      step("R8", 1'b0, 0, 0, 0, 0, 1'b1, 1);

      // R9: held tag refused; R7: idle-tag release and out-of-order release
      step("R9", 1'b1, 0, 0, 0, 0, 1'b0, 0);
      step("R9", 1'b1, 1, 0, 0, 0, 1'b0, 0);
      step("R5", 1'b1, 0, 0, 1, 1, 1'b0, 0);
      step("R7", 1'b0, 0, 0, 0, 0, 1'b1, 2);
      step("R7", 1'b0, 0, 0, 0, 0, 1'b1, 1);
      step("R5", 1'b1, 0, 1, 0, 2, 1'b0, 0);
      step("R7", 1'b0, 0, 0, 0, 0, 1'b1, 0);
      step("R3", 1'b1, 0, 1, 0, 2, 1'b0, 0);
      step("R7", 1'b0, 0, 0, 0, 0, 1'b1, 2);

      // Random traffic against the lane model: R3
      for (int i = 0; i < 4000; i++) begin
         step("R3", bit'($urandom_range(0, 1)), int'($urandom_range(0, NREG-1)),
              int'($urandom_range(0, 3)), int'($urandom_range(0, 7)),
              int'($urandom_range(0, NTAG-1)), bit'($urandom_range(0, 1)),
              int'($urandom_range(0, NTAG-1)));
      end
      idle();

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule